// File: doc/BRIEF.md
# Conversion Result Window Watchdog

This block watches the stream of finished conversion results from a sampling converter. It flags any result that lies outside a programmable window bounded by a low and a high threshold. Each result arrives with a one-cycle valid strobe, a right-aligned 12-bit value, a channel number and a tag that names its group. The tag is 0 for the regular group and 1 for the inserted group. Results are compared before any alignment or offset step further down the data path.

Monitoring can be limited to the regular group, the inserted group, or both. It can also be narrowed further to a single selected channel. A qualifying out-of-window result sets a sticky event flag. An interrupt line follows that flag whenever the interrupt enable is set. Software programs the block through a small write port and clears the flag through the same port.

Top module: `result_window_watchdog`

## Requirements
- R1: After reset, the event flag and the interrupt are low. The low threshold is 0 and the high threshold is 4095. Both group enables, single-channel mode and the interrupt enable are off.
- R2: A result that is valid and qualified raises the event flag on the clock edge after its valid cycle. A result qualifies when it is strictly greater than the high threshold or strictly less than the low threshold. A value equal to either threshold does not raise it.
- R3: A write to address 0 loads the low threshold from wr_data[11:0]. A write to address 1 loads the high threshold from wr_data[11:0].
- R4: A result with tag 0 is checked only while the regular enable is set. A result with tag 1 is checked only while the inserted enable is set.
- R5: A write to address 2 first clears both group enables and single-channel mode. It then sets the regular enable from wr_data[0] and the inserted enable from wr_data[1]. Code 00 turns monitoring off and code 11 monitors both groups.
- R6: A write to address 3 sets single-channel mode from wr_data[5] and the selected channel from wr_data[4:0]. While that mode is on, only results carrying the selected channel are checked, and the group enables still apply.
- R7: A write to address 3 whose channel field is above 18 is ignored as a whole. The previous mode and channel are kept.
- R8: Once set, the event flag stays set while later results fall back inside the window.
- R9: A write to address 4 with wr_data[0]=0 clears the event flag. Writing 1 there has no effect. A qualifying result in the same cycle as a clear write leaves the flag set.
- R10: The interrupt output is high exactly when the event flag is set and the interrupt enable is set. The interrupt enable is loaded from wr_data[0] by a write to address 5.
- R11: While res_valid is low, the result inputs have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Result strobe, one cycle per result |
| res_data | input | 12 | Right-aligned result value |
| res_chan | input | 5 | Channel that produced the result |
| res_inserted | input | 1 | Group tag: 0 regular, 1 inserted |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 12 | Register write data |
| evt_flag | output | 1 | Sticky out-of-window event flag |
| irq | output | 1 | Interrupt: flag gated by enable |

## Verification
The bench sweeps values on and next to each threshold. A comparator that used an inclusive bound, or that was off by one, would flag results that sit exactly on a threshold. It also checks that a group command drops single-channel mode; a design that kept the old selection would ignore results from other channels. Two more corner cases are covered. A clear write that lands in the same cycle as a new event must leave the flag set, since otherwise the event would be lost. An out-of-range channel write must be ignored; a design that took it anyway would silence the watchdog or aim it at a channel that does not exist.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    parameter int unsigned WDG_DATA_W   = 12;
    parameter int unsigned WDG_CHAN_W   = 5;
    parameter int unsigned WDG_MAX_CHAN = 18;
    parameter int unsigned WDG_ADDR_W   = 3;

    // register addresses of the write port
    localparam logic [WDG_ADDR_W-1:0] ADR_LOW   = WDG_ADDR_W'(0);
    localparam logic [WDG_ADDR_W-1:0] ADR_HIGH  = WDG_ADDR_W'(1);
    localparam logic [WDG_ADDR_W-1:0] ADR_GROUP = WDG_ADDR_W'(2);
    localparam logic [WDG_ADDR_W-1:0] ADR_CHAN  = WDG_ADDR_W'(3);
    localparam logic [WDG_ADDR_W-1:0] ADR_STAT  = WDG_ADDR_W'(4);
    localparam logic [WDG_ADDR_W-1:0] ADR_IEN   = WDG_ADDR_W'(5);

    typedef struct packed {
        logic [WDG_DATA_W-1:0] lo;
        logic [WDG_DATA_W-1:0] hi;
        logic                  grp_reg;
        logic                  grp_ins;
        logic                  single;
        logic [WDG_CHAN_W-1:0] sel;
        logic                  irq_en;
    } wdg_cfg_t;

endpackage

// File: rtl/wdg_cfg_regs.sv
module wdg_cfg_regs
    import wdg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [WDG_ADDR_W-1:0] wr_addr,
    input  logic [WDG_DATA_W-1:0] wr_data,
    output wdg_cfg_t              cfg,
    output logic                  clr_req
);

    localparam logic [WDG_CHAN_W-1:0] MAX_CHAN_V = WDG_CHAN_W'(WDG_MAX_CHAN);

    wdg_cfg_t cfg_d, cfg_q;
    logic     chan_legal;

    always_comb begin
        cfg_d      = cfg_q;
        chan_legal = (wr_data[WDG_CHAN_W-1:0] <= MAX_CHAN_V);
        clr_req    = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                ADR_LOW:  cfg_d.lo = wr_data;
                ADR_HIGH: cfg_d.hi = wr_data;
                ADR_GROUP: begin
                    // wipe the whole selection, then apply the new group code
                    cfg_d.single  = 1'b0;
                    cfg_d.grp_reg = wr_data[0];
                    cfg_d.grp_ins = wr_data[1];
                end
                ADR_CHAN: begin
                    if (chan_legal) begin
                        cfg_d.single = wr_data[WDG_CHAN_W];
                        cfg_d.sel    = wr_data[WDG_CHAN_W-1:0];
                    end
                end
                ADR_STAT: clr_req = ~wr_data[0];
                ADR_IEN:  cfg_d.irq_en = wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.lo      <= '0;
            cfg_q.hi      <= '1;
            cfg_q.grp_reg <= 1'b0;
            cfg_q.grp_ins <= 1'b0;
            cfg_q.single  <= 1'b0;
            cfg_q.sel     <= '0;
            cfg_q.irq_en  <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/wdg_screen.sv
module wdg_screen
    import wdg_pkg::*;
(
    input  logic                  res_valid,
    input  logic [WDG_DATA_W-1:0] res_data,
    input  logic [WDG_CHAN_W-1:0] res_chan,
    input  logic                  res_inserted,
    input  logic [WDG_DATA_W-1:0] lo,
    input  logic [WDG_DATA_W-1:0] hi,
    input  logic                  grp_reg,
    input  logic                  grp_ins,
    input  logic                  single,
    input  logic [WDG_CHAN_W-1:0] sel,
    output logic                  hit
);

    logic grp_ok;
    logic chan_ok;
    logic above;
    logic below;

    always_comb begin
        grp_ok  = res_inserted ? grp_ins : grp_reg;
        chan_ok = ~single | (res_chan == sel);
        above   = (res_data > hi);
        below   = (res_data < lo);
        hit     = res_valid & grp_ok & chan_ok & (above | below);
    end

endmodule

// File: rtl/wdg_event.sv
module wdg_event (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr_req,
    output logic flag
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_req) flag_d = 1'b0;
        // a new event outranks a clear in the same cycle
        if (hit)     flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

endmodule

// File: rtl/result_window_watchdog.sv
module result_window_watchdog
    import wdg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  res_valid,
    input  logic [WDG_DATA_W-1:0] res_data,
    input  logic [WDG_CHAN_W-1:0] res_chan,
    input  logic                  res_inserted,
    input  logic                  wr_en,
    input  logic [WDG_ADDR_W-1:0] wr_addr,
    input  logic [WDG_DATA_W-1:0] wr_data,
    output logic                  evt_flag,
    output logic                  irq
);

    wdg_cfg_t cfg;
    logic     clr_req;
    logic     hit;

    wdg_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .clr_req (clr_req)
    );

    wdg_screen u_screen (
        .res_valid    (res_valid),
        .res_data     (res_data),
        .res_chan     (res_chan),
        .res_inserted (res_inserted),
        .lo           (cfg.lo),
        .hi           (cfg.hi),
        .grp_reg      (cfg.grp_reg),
        .grp_ins      (cfg.grp_ins),
        .single       (cfg.single),
        .sel          (cfg.sel),
        .hit          (hit)
    );

    wdg_event u_event (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr_req (clr_req),
        .flag    (evt_flag)
    );

    assign irq = evt_flag & cfg.irq_en;

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
    import wdg_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  res_valid,
    input logic                  hit,
    input logic                  wr_en,
    input logic [WDG_ADDR_W-1:0] wr_addr,
    input logic                  wr_lsb,
    input logic                  evt_flag,
    input logic                  irq
);

    logic clr_wr;
    assign clr_wr = wr_en && (wr_addr == ADR_STAT) && !wr_lsb;

    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> evt_flag); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        evt_flag && !clr_wr |=> evt_flag); // R8

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        evt_flag && clr_wr && !hit |=> !evt_flag); // R9

    AST_CLEAR_LOSES_TO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && hit |=> evt_flag); // R9

    AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_flag && !res_valid |=> !evt_flag); // R11

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> evt_flag); // R10

endmodule

bind result_window_watchdog wdg_checker i_wdg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .hit       (hit),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_lsb    (wr_data[0]),
    .evt_flag  (evt_flag),
    .irq       (irq)
);

// File: tb/test_result_window_watchdog.sv
module test_result_window_watchdog;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic [4:0]  res_chan = '0;
    logic        res_inserted = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        evt_flag;
    logic        irq;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    // bench model of the programmed state
    int m_lo = 0, m_hi = 4095, m_sel = 0;
    bit m_reg = 0, m_ins = 0, m_single = 0, m_ie = 0, m_flag = 0;

    always #2.5 clk = ~clk;

    result_window_watchdog i_result_window_watchdog (
        .clk          (clk),
        .rst_n        (rst_n),
        .res_valid    (res_valid),
        .res_data     (res_data),
        .res_chan     (res_chan),
        .res_inserted (res_inserted),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .evt_flag     (evt_flag),
        .irq          (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 3'(a);
        wr_data = 12'(d);
        @(negedge clk);
        wr_en   = 1'b0;
        case (a)
            0: m_lo = d;
            1: m_hi = d;
            2: begin m_reg = d[0]; m_ins = d[1]; m_single = 0; end
            3: if ((d & 31) <= 18) begin m_single = d[5]; m_sel = d & 31; end
            4: if (!d[0]) m_flag = 0;
            5: m_ie = d[0];
            default: ;
        endcase
    endtask

    function automatic bit want_hit(input int d, input int ch, input bit ins);
        bit g;
        g = ins ? m_ins : m_reg;
        return g && (!m_single || ch == m_sel) && (d > m_hi || d < m_lo);
    endfunction

    task automatic apply(input int d, input int ch, input bit ins, input string req);
        @(negedge clk);
        res_valid    = 1'b1;
        res_data     = 12'(d);
        res_chan     = 5'(ch);
        res_inserted = ins;
        @(negedge clk);
        res_valid = 1'b0;
        m_flag = m_flag | want_hit(d, ch, ins);
        chk(req, int'(evt_flag), int'(m_flag));
        chk("R10", int'(irq), int'(m_flag && m_ie));
    endtask

    task automatic clear_flag();
        wr(4, 0);
        chk("R9", int'(evt_flag), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        chk("R1", int'(evt_flag), 0);
        chk("R1", int'(irq), 0);
        apply(4095, 0, 0, "R1");   // no group enabled
        apply(0, 0, 1, "R1");
        wr(2, 3);
        apply(4095, 0, 0, "R1");   // default high threshold is 4095
        apply(0, 7, 1, "R1");      // default low threshold is 0

        // R11: strobe low ignores an out-of-window value
        wr(1, 100);
        @(negedge clk);
        res_data = 12'd4000;
        res_chan = 5'd1;
        @(negedge clk);
        @(negedge clk);
        chk("R11", int'(evt_flag), 0);

        // R3 + R8 + R10: sticky flag and gated interrupt
        wr(0, 50);
        apply(4000, 1, 0, "R3");
        chk("R10", int'(irq), 0);
        apply(70, 1, 0, "R8");
        apply(80, 2, 1, "R8");
        chk("R8", int'(evt_flag), 1);
        wr(5, 1);
        chk("R10", int'(irq), 1);
        wr(4, 1);
        chk("R9", int'(evt_flag), 1);      // writing 1 does nothing
        clear_flag();
        chk("R10", int'(irq), 0);

        // R9: a clear and an event in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 12'd0;
        res_valid = 1'b1; res_data = 12'd4000; res_chan = 5'd3; res_inserted = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; res_valid = 1'b0;
        m_flag = 1;
        chk("R9", int'(evt_flag), 1);
        clear_flag();

        // R6 + R7: single channel and an illegal channel write
        wr(3, 32 | 5);
        apply(4000, 6, 0, "R6");
        apply(4000, 5, 0, "R6");
        clear_flag();
        wr(3, 32 | 25);
        apply(4000, 25, 0, "R7");
        apply(4000, 6, 1, "R7");
        apply(4000, 5, 1, "R7");
        clear_flag();

        // R5: group command drops single-channel mode
        wr(3, 32 | 9);
        wr(2, 1);
        apply(4000, 4, 0, "R5");
        apply(4000, 4, 1, "R5");
        clear_flag();
        wr(2, 0);
        apply(4000, 9, 0, "R5");
        apply(4000, 9, 1, "R5");

        // sweep: thresholds x groups x single mode x values x channel x tag
        for (int t = 0; t < 3; t++) begin
            int lo, hi;
            case (t)
                0: begin lo = 100;  hi = 3000; end
                1: begin lo = 0;    hi = 4095; end
                default: begin lo = 2048; hi = 2048; end
            endcase
            wr(0, lo);
            wr(1, hi);
            for (int g = 0; g < 4; g++) begin
                for (int s = 0; s < 2; s++) begin
                    wr(2, g);
                    if (s == 1) wr(3, 32 | 5);
                    for (int p = 0; p < 46; p++) begin
                        int d;
                        case (p)
                            42: d = lo - 1;
                            43: d = lo;
                            44: d = hi;
                            45: d = hi + 1;
                            default: d = (p * 100 > 4095) ? 4095 : p * 100;
                        endcase
                        if (d < 0 || d > 4095) continue;
                        for (int c = 0; c < 2; c++) begin
                            for (int n = 0; n < 2; n++) begin
                                apply(d, 5 + c, n[0],
                                      (s == 1) ? "R6" : ((g != 3) ? "R4" : "R2"));
                                clear_flag();
                            end
                        end
                    end
                end
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule